// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral guards a system against software that has stopped running. It holds a down-counter that software loads with a period. When the counter runs out for the first time, the block raises an interrupt and starts the count again from the stored period. If the counter runs out a second time before software has cleared that interrupt, and reset generation is enabled, the block asserts a system reset request. Software keeps the system alive by clearing the interrupt or by rewriting the period. Either action restarts the count.

Every register is reached over a simple APB-style bus with a setup phase and an access phase. The bus has no wait states, and a read returns data in the access phase. This block has no data stream, so there is no valid/ready pair and no back-pressure: every access completes in its access cycle. A key register protects the configuration against stray writes. Until the unlock key has been written, writes to every other register are dropped.

Top module: `wdog_dual`

## Requirements
- R1: After reset the block is locked, the period, count, control, raw flag and reset request are all zero, and `irq` and `sys_rst` are low.
- R2: While locked, a write to any offset other than the lock register changes no state, and this includes a write to the clear register.
- R3: Writing 0x1ACCE551 to the lock register (offset 0xC00) unlocks the block. Writing any other value locks it. A read of that offset returns 1 in bit 0 when the block is locked and 0 when it is unlocked.
- R4: The register offsets are period 0x000 (read/write), current count 0x004 (read-only), control 0x008, interrupt clear 0x00C, raw status 0x010 and masked status 0x014. Control bit 0 enables counting and the interrupt. Control bit 1 enables reset generation.
- R5: A write to the period register reloads the count with the written value on the same edge. While control bit 0 is set, the count drops by one on every clock. While control bit 0 is clear, the count holds its value.
- R6: When the count is zero at an enabled edge, the raw flag (bit 0 of raw status) is set and the count reloads from the period.
- R7: A zero count at an enabled edge while the raw flag is already set, with control bit 1 set, asserts `sys_rst`. The request then stays high until it is cleared or the block is reset. With control bit 1 clear, `sys_rst` never rises.
- R8: With no interrupt pending and the count at C after some edge, the interrupt rises C+1 enabled edges later. The reset request rises a further P+1 edges after that, where P is the period.
- R9: A write of any value to the clear register drops the raw flag and the reset request, and reloads the count from the period.
- R10: Bit 0 of masked status equals the raw flag ANDed with control bit 0, and `irq` follows that bit.
- R11: With control and period both written to zero, neither `irq` nor `sys_rst` is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq | output | 1 | Masked interrupt |
| sys_rst | output | 1 | System reset request |

## Verification
A write takes effect on the clock edge that ends its access phase. The bench's write task returns just after that edge, so register, flag and output effects are sampled at the very next falling edge. Expiry timing is measured by counting falling edges from the control write that starts the count: with a period of 5, the interrupt is due on the 6th edge and the reset request on the 12th, and the bench records the first edge on which each output is seen high. Count readings are taken in back-to-back reads spaced exactly two clocks apart, so a running counter must differ by 2 between them and a held counter by 0.

// File: rtl/wdog_dual_pkg.sv
package wdog_dual_pkg;
  localparam int unsigned OFS_PERIOD = 32'h000;
  localparam int unsigned OFS_COUNT  = 32'h004;
  localparam int unsigned OFS_CTRL   = 32'h008;
  localparam int unsigned OFS_CLEAR  = 32'h00C;
  localparam int unsigned OFS_RAW    = 32'h010;
  localparam int unsigned OFS_MASKED = 32'h014;
  localparam int unsigned OFS_KEY    = 32'hC00;

  localparam logic [31:0] UNLOCK_WORD = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_dual_regs.sv
module wdog_dual_regs
  import wdog_dual_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] period_q,
  output ctrl_t             ctrl_q,
  output logic              locked_q,
  output logic              reload,
  output logic [DATA_W-1:0] reload_val,
  output logic              clr
);
  logic hit_period, hit_ctrl, hit_clear, hit_key, open_wr;

  assign hit_period = wr_addr == ADDR_W'(OFS_PERIOD);
  assign hit_ctrl   = wr_addr == ADDR_W'(OFS_CTRL);
  assign hit_clear  = wr_addr == ADDR_W'(OFS_CLEAR);
  assign hit_key    = wr_addr == ADDR_W'(OFS_KEY);
  assign open_wr    = wr_stb && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      period_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_stb && hit_key)
        locked_q <= (wr_data != DATA_W'(UNLOCK_WORD));
      if (open_wr && hit_period)
        period_q <= wr_data;
      if (open_wr && hit_ctrl)
        ctrl_q <= ctrl_t'(wr_data[1:0]);
    end
  end

  assign clr        = open_wr && hit_clear;
  assign reload     = open_wr && (hit_period || hit_clear);
  assign reload_val = hit_period ? wr_data : period_q;

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && wr_stb && !hit_key |=> $stable(period_q) && $stable(ctrl_q)); // R2
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && hit_key && wr_data == DATA_W'(UNLOCK_WORD) |=> !locked_q); // R3
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && hit_key && wr_data != DATA_W'(UNLOCK_WORD) |=> locked_q); // R3
endmodule

// File: rtl/wdog_dual_count.sv
module wdog_dual_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              rst_en,
  input  logic [DATA_W-1:0] period,
  input  logic              reload,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              clr,
  output logic [DATA_W-1:0] cnt_q,
  output logic              raw_q,
  output logic              sysrst_q
);
  logic expire;

  assign expire = run_en && !reload && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      raw_q    <= 1'b0;
      sysrst_q <= 1'b0;
    end else begin
      if (reload)
        cnt_q <= reload_val;
      else if (run_en)
        cnt_q <= expire ? period : cnt_q - 1'b1;

      if (clr)
        raw_q <= 1'b0;
      else if (expire)
        raw_q <= 1'b1;

      if (clr)
        sysrst_q <= 1'b0;
      else if (expire && raw_q && rst_en)
        sysrst_q <= 1'b1;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !reload |=> $stable(cnt_q)); // R5
  AST_RELOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(reload_val)); // R5
  AST_RST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysrst_q) |-> $past(raw_q) && $past(rst_en)); // R7
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_q && !clr |=> sysrst_q); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !raw_q && !sysrst_q); // R9
endmodule

// File: rtl/wdog_dual.sv
module wdog_dual
  import wdog_dual_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              sys_rst
);
  logic              wr_stb, locked, reload, clr, raw, masked;
  logic [DATA_W-1:0] period, reload_val, cnt;
  ctrl_t             ctrl;

  assign wr_stb = psel && penable && pwrite;

  wdog_dual_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(paddr),
    .wr_data(pwdata), .period_q(period), .ctrl_q(ctrl), .locked_q(locked),
    .reload(reload), .reload_val(reload_val), .clr(clr)
  );

  wdog_dual_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run_en(ctrl.run_en), .rst_en(ctrl.rst_en),
    .period(period), .reload(reload), .reload_val(reload_val), .clr(clr),
    .cnt_q(cnt), .raw_q(raw), .sysrst_q(sys_rst)
  );

  assign masked = raw && ctrl.run_en;
  assign irq    = masked;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (paddr)
        ADDR_W'(OFS_PERIOD): prdata = period;
        ADDR_W'(OFS_COUNT):  prdata = cnt;
        ADDR_W'(OFS_CTRL):   prdata = DATA_W'(ctrl);
        ADDR_W'(OFS_RAW):    prdata = DATA_W'(raw);
        ADDR_W'(OFS_MASKED): prdata = DATA_W'(masked);
        ADDR_W'(OFS_KEY):    prdata = DATA_W'(locked);
        default:             prdata = '0;
      endcase
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl.run_en); // R10
endmodule

// File: tb/wdog_dual_test.sv
module wdog_dual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq, sys_rst;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  wdog_dual uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .sys_rst(sys_rst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    #1 d = prdata;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", sys_rst, 0);
    rd(12'hC00, v); chk("R1 locked", v, 1);
    rd(12'h000, v); chk("R1 period", v, 0);
    rd(12'h008, v); chk("R1 ctrl", v, 0);
    rd(12'h004, v); chk("R1 count", v, 0);
  endtask

  task automatic t_locked_writes;
    logic [31:0] v;
    wr(12'h000, 32'h55);
    rd(12'h000, v); chk("R2 period while locked", v, 0);
    wr(12'h008, 32'h3);
    rd(12'h008, v); chk("R2 ctrl while locked", v, 0);
  endtask

  task automatic t_key;
    logic [31:0] v;
    wr(12'hC00, 32'h1ACCE551);
    rd(12'hC00, v); chk("R3 unlocked", v, 0);
    wr(12'hC00, 32'h1);
    rd(12'hC00, v); chk("R3 relocked", v, 1);
    wr(12'hC00, 32'h1ACCE551);
  endtask

  task automatic t_count_rate;
    logic [31:0] a, b;
    wr(12'h000, 32'd100);
    rd(12'h004, a); chk("R5 load reloads count", a, 100);
    idle(10);
    rd(12'h004, a); chk("R5 hold when off", a, 100);
    wr(12'h008, 32'h1);
    rd(12'h004, a);
    rd(12'h004, b); chk("R5 one per clock", a - b, 2);
    rd(12'h008, a); chk("R4 ctrl readback", a, 1);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_two_stage;
    logic [31:0] v;
    int first_irq = -1, first_rst = -1;
    wr(12'h00C, 32'h0);
    wr(12'h000, 32'd5);
    wr(12'h008, 32'h3);
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (irq && first_irq < 0) first_irq = n;
      if (sys_rst && first_rst < 0) first_rst = n;
    end
    chk("R6 R8 first expiry edge", first_irq, 6);
    chk("R7 R8 second expiry edge", first_rst, 12);
    chk("R7 reset held", sys_rst, 1);
    rd(12'h010, v); chk("R6 raw flag", v, 1);
    rd(12'h014, v); chk("R10 masked flag", v, 1);
    wr(12'h00C, 32'hDEAD);
    chk("R9 reset dropped", sys_rst, 0);
    chk("R9 irq dropped", irq, 0);
    wr(12'h008, 32'h0);
    rd(12'h010, v); chk("R9 raw cleared", v, 0);
    rd(12'h004, v); chk("R9 count reloaded and running", v, 32'd3);
  endtask

  task automatic t_mask_and_norst;
    logic [31:0] v;
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h1);
    idle(20);
    chk("R6 irq pending", irq, 1);
    chk("R7 no reset when disabled", sys_rst, 0);
    wr(12'h008, 32'h0);
    chk("R10 irq masked", irq, 0);
    rd(12'h010, v); chk("R10 raw kept", v, 1);
    rd(12'h014, v); chk("R10 masked zero", v, 0);
    wr(12'hC00, 32'h1);
    wr(12'h00C, 32'h0);
    wr(12'hC00, 32'h1ACCE551);
    rd(12'h010, v); chk("R2 clear ignored while locked", v, 1);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h0);
    wr(12'h000, 32'h0);
    idle(50);
    chk("R11 no irq", irq, 0);
    chk("R11 no reset", sys_rst, 0);
    rd(12'h010, v); chk("R11 raw stays low", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_writes();
    t_key();
    t_count_rate();
    t_two_stage();
    t_mask_and_norst();
    t_disabled();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule